// File: doc/BRIEF.md
# Condition Evaluator and Branch Target Unit

This block decides whether a flag condition holds for a conditional-branch or conditional-set instruction. It accepts the opcode byte, the five arithmetic status flags (overflow, sign, zero, parity, carry), the operand-size mode, a branch displacement and the instruction pointer. The upper nibble selects the form and the lower nibble selects one of eight conditions and whether it is negated.

For a branch, the block sign-extends a short displacement (or uses a full-width one in wide mode) and computes the next instruction pointer. The incoming pointer already points past the displacement. For a set, it produces a byte of value 0 or 1 for a later store stage. An opcode of any other form is flagged invalid and has no effect. All results are registered and appear one clock after the request.

Top module: `branch_cond_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid`, `taken`, `invalid`, `set_byte` and `next_ip` are all zero until the first request.
- R2: A request sampled with `in_valid` high at a rising edge produces its results and `out_valid` high right after that same edge; `out_valid` is low after any edge where `in_valid` was low.
- R3: `flags` bit positions are 4 = OF, 3 = SF, 2 = ZF, 1 = PF, 0 = CF; opcode bits 3:1 select the condition 0 = OF, 1 = CF, 2 = ZF, 3 = CF|ZF, 4 = SF, 5 = PF, 6 = SF^OF, 7 = (SF^OF)|ZF.
- R4: Opcode bit 0 set negates the selected condition.
- R5: An opcode with upper nibble 0x8 is a branch; when its condition holds, `taken` is 1 and with `op_wide` = 0 `next_ip` = `ip_in` + `disp[15:0]` sign-extended to 32 bits, with `disp[31:16]` ignored.
- R6: With `op_wide` = 1 a taken branch adds all 32 bits of `disp` to `ip_in`.
- R7: A branch whose condition fails gives `taken` = 0 and `next_ip` = `ip_in`.
- R8: The pointer addition wraps modulo 2^32.
- R9: An opcode with upper nibble 0x9 is a set; `set_byte` is 0x01 when the condition holds and 0x00 otherwise, `taken` is 0 and `next_ip` = `ip_in`. For a branch `set_byte` is 0x00.
- R10: Any other upper nibble raises `invalid`, with `taken` = 0, `set_byte` = 0x00 and `next_ip` = `ip_in`.
- R11: While `in_valid` is low the result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Second opcode byte (form nibble, condition nibble) |
| flags | input | 5 | Status flags {OF, SF, ZF, PF, CF} |
| op_wide | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| disp | input | 32 | Branch displacement |
| ip_in | input | 32 | Pointer to the byte after the instruction |
| out_valid | output | 1 | Results below belong to the previous request |
| taken | output | 1 | Branch condition held |
| set_byte | output | 8 | Set result, 0x00 or 0x01 |
| next_ip | output | 32 | Next instruction pointer |
| invalid | output | 1 | Opcode form not recognised |

## Verification
Every result (`taken`, `set_byte`, `next_ip`, `invalid`, `out_valid`) is due exactly one rising edge after the request is sampled, because there is a single output register stage. The bench drives each request on a falling edge and reads all outputs at the next falling edge. That is half a period after the registering edge and before the following one. A directed test also reads `out_valid` between driving a request and its edge to confirm the result is not early. An idle cycle confirms that held values survive.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

   // Status flags in the bit order used on the flags port.
   typedef struct packed {
      logic of_f;
      logic sf_f;
      logic zf_f;
      logic pf_f;
      logic cf_f;
   } bcu_flags_t;

   localparam int FLAG_W = $bits(bcu_flags_t);

   typedef enum logic [1:0] {
      FORM_BRANCH = 2'd0,
      FORM_SET    = 2'd1,
      FORM_BAD    = 2'd2
   } bcu_form_e;

endpackage

// File: rtl/bcu_cond_table.sv
module bcu_cond_table
   import bcu_pkg::*;
(
   input  bcu_flags_t flg,
   input  logic [2:0] sel,
   input  logic       negate,
   output logic       holds
);
   logic less;
   logic raw;

   assign less = flg.sf_f ^ flg.of_f;

   always_comb begin
      unique case (sel)
         3'd0: raw = flg.of_f;
         3'd1: raw = flg.cf_f;
         3'd2: raw = flg.zf_f;
         3'd3: raw = flg.cf_f | flg.zf_f;
         3'd4: raw = flg.sf_f;
         3'd5: raw = flg.pf_f;
         3'd6: raw = less;
         default: raw = less | flg.zf_f;
      endcase
   end

   assign holds = raw ^ negate;
endmodule

// File: rtl/bcu_disp_ext.sv
module bcu_disp_ext #(
   parameter int ADDR_W  = 32,
   parameter int SHORT_W = 16
) (
   input  logic [ADDR_W-1:0] disp,
   input  logic              op_wide,
   output logic [ADDR_W-1:0] ext
);
   generate
      if (SHORT_W < ADDR_W) begin : g_narrow
         logic [ADDR_W-1:0] short_ext;
         assign short_ext = {{(ADDR_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
         assign ext = op_wide ? disp : short_ext;
      end else begin : g_same
         logic unused_mode;
         assign unused_mode = op_wide;
         assign ext = disp;
      end
   endgenerate
endmodule

// File: rtl/bcu_form_dec.sv
module bcu_form_dec
   import bcu_pkg::*;
#(
   parameter int         OPC_W      = 8,
   parameter logic [3:0] BRANCH_NIB = 4'h8,
   parameter logic [3:0] SET_NIB    = 4'h9
) (
   input  logic [OPC_W-1:0] opcode,
   output bcu_form_e        form,
   output logic [2:0]       sel,
   output logic             negate
);
   localparam int TOP = OPC_W - 1;
   logic [3:0] hi;

   assign hi     = opcode[TOP -: 4];
   assign sel    = opcode[3:1];
   assign negate = opcode[0];

   always_comb begin
      if (hi == BRANCH_NIB)   form = FORM_BRANCH;
      else if (hi == SET_NIB) form = FORM_SET;
      else                    form = FORM_BAD;
   end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
   import bcu_pkg::*;
#(
   parameter int         ADDR_W     = 32,
   parameter int         SHORT_W    = 16,
   parameter int         OPC_W      = 8,
   parameter int         SET_W      = 8,
   parameter logic [3:0] BRANCH_NIB = 4'h8,
   parameter logic [3:0] SET_NIB    = 4'h9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [FLAG_W-1:0] flags,
   input  logic              op_wide,
   input  logic [ADDR_W-1:0] disp,
   input  logic [ADDR_W-1:0] ip_in,
   output logic              out_valid,
   output logic              taken,
   output logic [SET_W-1:0]  set_byte,
   output logic [ADDR_W-1:0] next_ip,
   output logic              invalid
);
   generate
      if (SHORT_W < 1 || SHORT_W > ADDR_W) begin : g_chk_short
         $error("SHORT_W must lie in 1..ADDR_W");
      end
      if (OPC_W < 8) begin : g_chk_opc
         $error("OPC_W must be at least 8");
      end
      if (SET_W < 2) begin : g_chk_set
         $error("SET_W must be at least 2");
      end
   endgenerate

   bcu_flags_t        flg;
   bcu_form_e         form;
   logic [2:0]        sel;
   logic              negate;
   logic              holds;
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] target;

   assign flg = bcu_flags_t'(flags);

   bcu_form_dec #(
      .OPC_W(OPC_W), .BRANCH_NIB(BRANCH_NIB), .SET_NIB(SET_NIB)
   ) u_dec (
      .opcode(opcode), .form(form), .sel(sel), .negate(negate)
   );

   bcu_cond_table u_tbl (
      .flg(flg), .sel(sel), .negate(negate), .holds(holds)
   );

   bcu_disp_ext #(
      .ADDR_W(ADDR_W), .SHORT_W(SHORT_W)
   ) u_ext (
      .disp(disp), .op_wide(op_wide), .ext(disp_ext)
   );

   assign target = ip_in + disp_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         taken     <= 1'b0;
         set_byte  <= '0;
         next_ip   <= '0;
         invalid   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            taken    <= (form == FORM_BRANCH) && holds;
            set_byte <= SET_W'((form == FORM_SET) && holds);
            next_ip  <= ((form == FORM_BRANCH) && holds) ? target : ip_in;
            invalid  <= (form == FORM_BAD);
         end
      end
   end
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
   parameter int         ADDR_W     = 32,
   parameter int         OPC_W      = 8,
   parameter int         SET_W      = 8,
   parameter logic [3:0] BRANCH_NIB = 4'h8,
   parameter logic [3:0] SET_NIB    = 4'h9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [OPC_W-1:0]  opcode,
   input logic              op_wide,
   input logic [ADDR_W-1:0] disp,
   input logic [ADDR_W-1:0] ip_in,
   input logic              out_valid,
   input logic              taken,
   input logic [SET_W-1:0]  set_byte,
   input logic [ADDR_W-1:0] next_ip,
   input logic              invalid
);
   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r6_wide_target: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && taken && $past(op_wide) |-> next_ip == $past(ip_in) + $past(disp));

   a_r7_hold_pointer: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !taken |-> next_ip == $past(ip_in));

   a_r9_set_shape: assert property (@(posedge clk) disable iff (!rst_n)
      set_byte[SET_W-1:1] == '0);

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(taken && set_byte[0]));

   a_r10_invalid_decode: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> invalid == ($past(opcode[OPC_W-1 -: 4]) != BRANCH_NIB &&
                                $past(opcode[OPC_W-1 -: 4]) != SET_NIB));

   a_r10_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      invalid |-> !taken && set_byte == '0);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(next_ip) && $stable(taken) && $stable(set_byte) && $stable(invalid));
endmodule

bind branch_cond_unit bcu_checker #(
   .ADDR_W(ADDR_W), .OPC_W(OPC_W), .SET_W(SET_W),
   .BRANCH_NIB(BRANCH_NIB), .SET_NIB(SET_NIB)
) u_bcu_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
   .op_wide(op_wide), .disp(disp), .ip_in(ip_in), .out_valid(out_valid),
   .taken(taken), .set_byte(set_byte), .next_ip(next_ip), .invalid(invalid)
);

// File: tb/branch_cond_unit_bench.sv
module branch_cond_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [7:0]  opcode;
   logic [4:0]  flags;
   logic        op_wide;
   logic [31:0] disp;
   logic [31:0] ip_in;
   logic        out_valid;
   logic        taken;
   logic [7:0]  set_byte;
   logic [31:0] next_ip;
   logic        invalid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   branch_cond_unit u_branch_cond_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .flags(flags), .op_wide(op_wide), .disp(disp), .ip_in(ip_in),
      .out_valid(out_valid), .taken(taken), .set_byte(set_byte),
      .next_ip(next_ip), .invalid(invalid)
   );

   // flags literal order {OF, SF, ZF, PF, CF}
   typedef struct packed {
      logic [7:0]  opc;
      logic [4:0]  flg;
      logic        wide;
      logic [31:0] dsp;
      logic [31:0] ip;
      logic        e_tk;
      logic [7:0]  e_set;
      logic [31:0] e_ip;
      logic        e_inv;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{8'h80, 5'b10000, 1'b1, 32'h0000_0100, 32'h0000_1000, 1'b1, 8'h00, 32'h0000_1100, 1'b0, 8'd3},  // R3 overflow
      '{8'h81, 5'b10000, 1'b1, 32'h0000_0100, 32'h0000_1000, 1'b0, 8'h00, 32'h0000_1000, 1'b0, 8'd4},  // R4 negated
      '{8'h82, 5'b00001, 1'b0, 32'hABCD_FFF0, 32'h0000_2000, 1'b1, 8'h00, 32'h0000_1FF0, 1'b0, 8'd5},  // R5 sign-extend
      '{8'h84, 5'b00000, 1'b1, 32'h0000_0010, 32'h0000_3000, 1'b0, 8'h00, 32'h0000_3000, 1'b0, 8'd7},  // R7 fail
      '{8'h86, 5'b00100, 1'b1, 32'h8000_0000, 32'h9000_0000, 1'b1, 8'h00, 32'h1000_0000, 1'b0, 8'd8},  // R8 wrap
      '{8'h88, 5'b01000, 1'b1, 32'h0001_0000, 32'h0000_0010, 1'b1, 8'h00, 32'h0001_0010, 1'b0, 8'd6},  // R6 wide
      '{8'h8A, 5'b00010, 1'b0, 32'h0000_7FFF, 32'h0000_0000, 1'b1, 8'h00, 32'h0000_7FFF, 1'b0, 8'd5},  // R5 positive
      '{8'h8C, 5'b01000, 1'b0, 32'h0000_0002, 32'hFFFF_FFFF, 1'b1, 8'h00, 32'h0000_0001, 1'b0, 8'd8},  // R8 wrap short
      '{8'h8D, 5'b11000, 1'b1, 32'h0000_0004, 32'h0000_0040, 1'b1, 8'h00, 32'h0000_0044, 1'b0, 8'd4},  // R4 not-less
      '{8'h8E, 5'b00100, 1'b1, 32'hFFFF_FFFC, 32'h0000_0040, 1'b1, 8'h00, 32'h0000_003C, 1'b0, 8'd3},  // R3 less-or-equal
      '{8'h8F, 5'b00100, 1'b1, 32'hFFFF_FFFC, 32'h0000_0040, 1'b0, 8'h00, 32'h0000_0040, 1'b0, 8'd7},  // R7 negated le
      '{8'h94, 5'b00100, 1'b0, 32'h0000_1234, 32'h0000_0500, 1'b0, 8'h01, 32'h0000_0500, 1'b0, 8'd9},  // R9 set zero
      '{8'h95, 5'b00100, 1'b0, 32'h0000_1234, 32'h0000_0500, 1'b0, 8'h00, 32'h0000_0500, 1'b0, 8'd9},  // R9 set not zero
      '{8'h9E, 5'b10000, 1'b1, 32'h0000_0000, 32'h0000_0500, 1'b0, 8'h01, 32'h0000_0500, 1'b0, 8'd3},  // R3 set le
      '{8'h97, 5'b00001, 1'b1, 32'h0000_0000, 32'h0000_0500, 1'b0, 8'h00, 32'h0000_0500, 1'b0, 8'd4},  // R4 set above
      '{8'h93, 5'b11110, 1'b1, 32'h0000_0000, 32'h0000_0500, 1'b0, 8'h01, 32'h0000_0500, 1'b0, 8'd9},  // R9 set no carry
      '{8'hA4, 5'b11111, 1'b1, 32'h0000_0100, 32'h0000_0700, 1'b0, 8'h00, 32'h0000_0700, 1'b1, 8'd10}, // R10
      '{8'h0F, 5'b11111, 1'b0, 32'h0000_0100, 32'h0000_0800, 1'b0, 8'h00, 32'h0000_0800, 1'b1, 8'd10}  // R10
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      in_valid = 1'b1;
      opcode   = v.opc;
      flags    = v.flg;
      op_wide  = v.wide;
      disp     = v.dsp;
      ip_in    = v.ip;
   endtask

   initial begin
      #(4 * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; opcode = '0; flags = '0;
      op_wide = 1'b0; disp = '0; ip_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(!out_valid && !taken && !invalid && set_byte == 8'h00 && next_ip == 32'h0,
            "R1", "reset outputs",
            {out_valid, taken, invalid, set_byte, next_ip}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && next_ip == 32'h0, "R1", "after release",
            {out_valid, next_ip}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         check(out_valid && taken == VECS[i].e_tk && set_byte == VECS[i].e_set &&
               next_ip == VECS[i].e_ip && invalid == VECS[i].e_inv,
               $sformatf("R%0d vec%0d", VECS[i].req, i), "{valid,tk,set,ip,inv}",
               {out_valid, taken, set_byte, next_ip, invalid},
               {1'b1, VECS[i].e_tk, VECS[i].e_set, VECS[i].e_ip, VECS[i].e_inv});
      end

      // R11 idle cycle: outputs hold, out_valid low (R2)
      in_valid = 1'b0;
      ip_in    = 32'hDEAD_0000;
      opcode   = 8'h80;
      flags    = 5'b11111;
      @(negedge clk);
      check(!out_valid, "R2", "idle out_valid", {63'h0, out_valid}, 64'h0);
      check(next_ip == 32'h0000_0800 && invalid && !taken, "R11", "held outputs",
            {invalid, taken, next_ip}, {1'b1, 1'b0, 32'h0000_0800});

      // R2 latency: not before the edge, present right after it
      drive('{8'h82, 5'b00001, 1'b1, 32'h0000_0020, 32'h0000_4000, 1'b1, 8'h00,
              32'h0000_4020, 1'b0, 8'd2});
      #1;
      check(!out_valid && next_ip == 32'h0000_0800, "R2", "result early",
            {out_valid, next_ip}, {1'b0, 32'h0000_0800});
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && taken && next_ip == 32'h0000_4020, "R2", "result due",
            {out_valid, taken, next_ip}, {1'b1, 1'b1, 32'h0000_4020});

      // R5 upper displacement bits ignored in short mode
      drive('{8'h8B, 5'b00000, 1'b0, 32'hFFFF_0010, 32'h0000_0100, 1'b1, 8'h00,
              32'h0000_0110, 1'b0, 8'd5});
      @(negedge clk);
      in_valid = 1'b0;
      check(taken && next_ip == 32'h0000_0110, "R5", "upper disp ignored",
            {taken, next_ip}, {1'b1, 32'h0000_0110});

      // R1 reset mid-run clears results
      rst_n = 1'b0;
      @(negedge clk);
      check(!out_valid && !taken && next_ip == 32'h0, "R1", "mid-run reset",
            {out_valid, taken, next_ip}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule